// File: doc/BRIEF.md
# Serial Configuration EEPROM Emulator

This block stands in for a small three-wire serial configuration EEPROM on the board of a network controller. After the host tells the controller to reload its setup, the controller clocks out read commands on its serial clock and expects configuration words back on the data line. The emulator watches that clock and answers with a fixed sequence of 16-bit words held in an internal table. It does not decode the command or the address it receives.

Every word uses the same frame of serial clock periods. A header is counted and ignored. A data phase follows, in which one bit is driven per period. A tail is then absorbed. A start pulse arms the block. When the last word has been served, it releases its outputs and pulses a done flag. If the serial clock goes quiet for longer than a limit given at a port, the block aborts, releases its outputs and raises a timeout flag.

The serial clock is asynchronous to the system clock. It is synchronised with two flops, and its edges are found in the system clock domain. The system clock must run at least four times faster than the serial clock.

Top module: `mw_eeprom_emu`

## Requirements
- R1: After reset, `do_oe`, `mode_oe`, `mode_out`, `do_out`, `done` and `timeout` are all low.
- R2: A `start` pulse raises `mode_out`, `mode_oe` and `do_oe` with `do_out` low, and resets the word and period counters. A `start` during a transaction restarts the sequence at word 0.
- R3: In the first 11 serial clock periods of each word, `do_out` stays low. This header holds a start bit, two opcode bits, seven address bits and a direction-change bit.
- R4: In periods 12 to 27 of each word, one data bit per period is driven on `do_out` at the rising serial clock edge. The high byte goes first, and each byte is sent most significant bit first.
- R5: After every falling serial clock edge, `do_out` returns low, so a 1 bit is high only between a rising edge and the next falling edge.
- R6: After the data bits, 5 more periods are absorbed with `do_out` low. Each word therefore takes 32 periods, and the next word's header starts with period 33.
- R7: Nine words are served in order. Word 0 is 0xFFFF. Word 1 is 0xFF30, with the fourth table byte 0x30 in the low half. Words 2 to 8 are 0xFFFF.
- R8: `done` is a one-system-clock pulse, raised once after the 32nd falling edge of the ninth word. All output enables are low from then on.
- R9: If an armed emulator sees no serial clock edge for more than `timeout_limit` system clocks, it drops all enables and `do_out`. It then holds `timeout` high until the next `start`, without raising `done`.
- R10: While not armed, serial clock activity changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that arms the emulator |
| timeout_limit | input | TO_W | Quiet system clocks tolerated between serial clock edges |
| sk_in | input | 1 | Serial clock from the controller (asynchronous) |
| do_out | output | 1 | Serial data to the controller |
| do_oe | output | 1 | Output enable for `do_out` |
| mode_out | output | 1 | Emulation-mode level, high while armed |
| mode_oe | output | 1 | Output enable for `mode_out` |
| done | output | 1 | Pulse when the last word has been served |
| timeout | output | 1 | Held high after an abort on a quiet serial clock |

## Verification
The bench uses the default frame of 11 + 16 + 5 periods and nine words, so it walks every word of the table, including the single non-filler byte. It drives `timeout_limit` to 40 and gives the serial clock half periods of six system clocks. This keeps normal frames well inside the limit, while a pause of 100 cycles reaches the abort path in a short run. A restart part-way into a frame and serial clock toggling before arming are also exercised.

// File: rtl/mw_eeprom_emu.sv
module mw_eeprom_emu #(
  parameter int HDR_CLKS   = 11,
  parameter int TAIL_CLKS  = 5,
  parameter int NUM_WORDS  = 9,
  parameter int TO_W       = 16,
  parameter logic [7:0] FILL_BYTE = 8'hFF,
  parameter int SPECIAL_IDX = 3,
  parameter logic [7:0] SPECIAL_BYTE = 8'h30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [TO_W-1:0] timeout_limit,
  input  logic            sk_in,
  output logic            do_out,
  output logic            do_oe,
  output logic            mode_out,
  output logic            mode_oe,
  output logic            done,
  output logic            timeout
);
  localparam int DATA_BITS = 16;
  localparam int FRAME     = HDR_CLKS + DATA_BITS + TAIL_CLKS;
  localparam int BC_W      = $clog2(FRAME);
  localparam int WC_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  function automatic logic [7:0] byte_at(int i);
    return (i == SPECIAL_IDX) ? SPECIAL_BYTE : FILL_BYTE;
  endfunction

  function automatic logic [DATA_BITS-1:0] word_at(int w);
    return {byte_at(2*w), byte_at(2*w+1)};
  endfunction

  logic sk_s1, sk_s2, sk_d;
  logic active;
  logic [BC_W-1:0] bit_cnt;
  logic [WC_W-1:0] word_cnt;
  logic [TO_W-1:0] idle_cnt;
  logic rise, fall, in_data, cur_bit;
  logic [DATA_BITS-1:0] cur_word;

  assign rise = sk_s2 & ~sk_d;
  assign fall = ~sk_s2 & sk_d;

  assign do_oe    = active;
  assign mode_oe  = active;
  assign mode_out = active;

  always_comb begin
    int pos;
    pos      = int'(bit_cnt) - HDR_CLKS;
    in_data  = (pos >= 0) && (pos < DATA_BITS);
    cur_word = word_at(int'(word_cnt));
    cur_bit  = in_data ? cur_word[DATA_BITS-1-(in_data ? pos : 0)] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_s1 <= 1'b0;
      sk_s2 <= 1'b0;
      sk_d  <= 1'b0;
    end else begin
      sk_s1 <= sk_in;
      sk_s2 <= sk_s1;
      sk_d  <= sk_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      bit_cnt  <= '0;
      word_cnt <= '0;
      idle_cnt <= '0;
      do_out   <= 1'b0;
      done     <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active   <= 1'b1;
        bit_cnt  <= '0;
        word_cnt <= '0;
        idle_cnt <= '0;
        do_out   <= 1'b0;
        timeout  <= 1'b0;
      end else if (active) begin
        if (rise || fall) begin
          idle_cnt <= '0;
        end else if (idle_cnt == timeout_limit) begin
          active  <= 1'b0;
          timeout <= 1'b1;
          do_out  <= 1'b0;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end

        if (rise && in_data) do_out <= cur_bit;

        if (fall) begin
          do_out <= 1'b0;
          if (bit_cnt == BC_W'(FRAME-1)) begin
            bit_cnt <= '0;
            if (word_cnt == WC_W'(NUM_WORDS-1)) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              word_cnt <= word_cnt + 1'b1;
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

  AST_LOW_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    active && fall && !start |=> !do_out); // R5
  AST_HDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    active && rise && !in_data && !start |=> !do_out); // R3
  AST_DATA_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    active && !rise && !fall && !start |=> $stable(do_out) || !do_oe); // R4
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !do_oe && !mode_oe); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !do_oe && !do_out && !done); // R9
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !do_oe && !start |=> !do_out && !do_oe); // R10
endmodule

// File: tb/tb_mw_eeprom_emu.sv
module tb_mw_eeprom_emu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] timeout_limit = 16'd40;
  logic sk_in = 1'b0;
  logic do_out, do_oe, mode_out, mode_oe, done, timeout;

  int checks = 0;
  int fails = 0;
  int done_pulses = 0;

  always #5 clk = ~clk;

  mw_eeprom_emu dut (
    .clk(clk), .rst_n(rst_n), .start(start), .timeout_limit(timeout_limit),
    .sk_in(sk_in), .do_out(do_out), .do_oe(do_oe), .mode_out(mode_out),
    .mode_oe(mode_oe), .done(done), .timeout(timeout)
  );

  localparam logic [15:0] EXP_WORDS [9] = '{
    16'hFFFF, 16'hFF30, 16'hFFFF, 16'hFFFF, 16'hFFFF,
    16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF
  };

  always @(negedge clk) if (done) done_pulses++;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic sk_period(input logic exp_hi, input string req);
    sk_in = 1'b1;
    repeat (6) @(negedge clk);
    chk(do_out === exp_hi, req, int'(do_out), int'(exp_hi));
    sk_in = 1'b0;
    repeat (6) @(negedge clk);
    chk(do_out === 1'b0, "R5", int'(do_out), 0);
  endtask

  task automatic run_word(input logic [15:0] w);
    for (int p = 0; p < 32; p++) begin
      if (p < 11)      sk_period(1'b0, "R3");
      else if (p < 27) sk_period(w[15-(p-11)], "R4_R7");
      else             sk_period(1'b0, "R6");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({do_oe, mode_oe, mode_out, do_out, done, timeout} === 6'b0, "R1",
        int'({do_oe, mode_oe, mode_out, do_out, done, timeout}), 0);

    // R10 serial clock ignored while idle
    for (int i = 0; i < 40; i++) begin
      sk_in = 1'b1; repeat (6) @(negedge clk);
      sk_in = 1'b0; repeat (6) @(negedge clk);
    end
    chk({do_oe, do_out, mode_out} === 3'b0 && done_pulses == 0, "R10",
        int'({do_oe, do_out, mode_out}), 0);

    // R2 arming
    pulse_start();
    @(negedge clk);
    chk({mode_out, mode_oe, do_oe, do_out} === 4'b1110, "R2",
        int'({mode_out, mode_oe, do_oe, do_out}), 'he);

    // R2 restart mid-frame: feed 15 periods, then restart and expect word 0
    for (int p = 0; p < 15; p++) begin
      sk_in = 1'b1; repeat (6) @(negedge clk);
      sk_in = 1'b0; repeat (6) @(negedge clk);
    end
    pulse_start();

    // R4, R6, R7 walk the table
    for (int w = 0; w < 9; w++) begin
      run_word(EXP_WORDS[w]);
      if (w < 8) chk(do_oe === 1'b1 && done_pulses == 0, "R6", int'(do_oe), 1);
    end
    // R8 done once, outputs released
    chk(done_pulses == 1, "R8", done_pulses, 1);
    chk({do_oe, mode_oe, mode_out} === 3'b0, "R8", int'({do_oe, mode_oe, mode_out}), 0);
    chk(timeout === 1'b0, "R8", int'(timeout), 0);

    // R9 timeout on quiet clock
    pulse_start();
    for (int p = 0; p < 3; p++) sk_period(1'b0, "R3");
    sk_in = 1'b1;
    repeat (100) @(negedge clk);
    chk(timeout === 1'b1, "R9", int'(timeout), 1);
    chk({do_oe, mode_oe, do_out} === 3'b0, "R9", int'({do_oe, mode_oe, do_out}), 0);
    chk(done_pulses == 1, "R9", done_pulses, 1);
    sk_in = 1'b0;
    repeat (20) @(negedge clk);
    chk(timeout === 1'b1, "R9", int'(timeout), 1);

    // R2 restart clears timeout and serves word 0 again
    pulse_start();
    @(negedge clk);
    chk(timeout === 1'b0 && do_oe === 1'b1, "R2", int'({timeout, do_oe}), 1);
    run_word(EXP_WORDS[0]);
    run_word(EXP_WORDS[1]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule